// File: doc/BRIEF.md
# System Clock Source and Mode Controller

This block owns the system clock configuration byte of a small controller and decides which of three sources drives the machine clock. The three sources are a low-speed subclock, the main oscillator, and a PLL fed by the main oscillator. Software writes one byte to request a mode, to park the subclock oscillator and to choose a divide ratio. Hardware then completes the change. It holds the request until the target source is usable. For the subclock, usable means an internal stabilization counter has run out. For the PLL, it means the lock input is high. Only then does it move the current mode and the source enable together.

The read-back byte reports the mode that is really in force next to the requested one. Software can therefore poll for completion. While a request is outstanding the select field is frozen. A parameter removes the subclock entirely for single-oscillator systems. In that case requests for subclock mode are dropped and the subclock bits read as zero. A divider turns the selected source into a machine clock enable pulse. It restarts cleanly whenever the source or the ratio changes.

Top module: `sysclk_mode_ctrl`

## Requirements
- R1: After reset the byte reads 8'hA0: current mode 10 (main), select 10, subclock ready 0, subclock stop 0, divide field 00. The source enable selects main.
- R2: Bits 7:6 report the current mode (00 subclock, 10 main, 11 PLL), never hold 01, and are not changed by writes.
- R3: While the select field (bits 5:4) differs from the current mode, writes to bits 5:4 are ignored. Bits 3:0 of such a write still take effect.
- R4: A write of 01 to bits 5:4 is ignored. With the subclock removed, a write of 00 is also ignored. In both cases the select field keeps its value.
- R5: A request for main mode completes on the clock edge after it is accepted. modeOut, bits 7:6 and the one-hot srcEn ({PLL, main, sub}) all switch on that same edge.
- R6: A request for PLL mode asserts pllEn at once. The mode changes on the first edge at which pllLock is sampled high.
- R7: A request for subclock mode re-enables a stopped subclock. The mode changes only on the edge after subclock ready is set, which is SUB_WAIT cycles after the oscillator is enabled.
- R8: In main or PLL mode, bit 2 = 1 drops subOscEn, and bit 3 (ready) clears one cycle later. Bit 2 = 0 re-enables the oscillator, and ready returns after SUB_WAIT cycles. In subclock mode, bit 2 has no effect on subOscEn or ready.
- R9: Bits 1:0 choose the machine clock ratio 1, 4, 8 or 16 (codes 00, 01, 10, 11). mclkTick pulses once per that many cycles.
- R10: The divider restarts whenever the mode or the divide field changes. mclkTick is high in the first cycle under the new setting.
- R11: With the subclock removed, bits 3 and 2 read 0 and subOscEn stays 0. Main and PLL switching still work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the configuration byte |
| wrData | input | 8 | Byte written when wrEn is high |
| pllLock | input | 1 | PLL lock indication |
| rdData | output | 8 | Configuration byte read-back |
| modeOut | output | 2 | Current clock mode |
| srcEn | output | 3 | One-hot source enable {PLL, main, sub} |
| subOscEn | output | 1 | Subclock oscillator enable |
| pllEn | output | 1 | PLL enable |
| divSel | output | 2 | Active divide field |
| mclkTick | output | 1 | Machine clock enable pulse |

## Verification
A mode register that advances early or late shows as bits 7:6 and srcEn disagreeing with the edge the bench predicts from the last accepted write and pllLock. The error is visible one cycle after the bad edge. A stuck pending condition shows up on the next select write, which reads back wrongly right after its edge. A stabilization counter that is off by one moves ready and the subclock mode switch by a cycle, and the exact-cycle checks catch it. A divider that fails to restart breaks the tick pattern within one divide period.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam logic [1:0] MODE_SUB  = 2'b00;
  localparam logic [1:0] MODE_BAD  = 2'b01;
  localparam logic [1:0] MODE_MAIN = 2'b10;
  localparam logic [1:0] MODE_PLL  = 2'b11;

  localparam int DIV_W = 4;

  typedef struct packed {
    logic selLoad;
    logic modeGo;
    logic subOscEn;
    logic pllEn;
  } ctrlStrobe_t;

  function automatic logic [2:0] srcOneHot(input logic [1:0] m);
    case (m)
      MODE_SUB: srcOneHot = 3'b001;
      MODE_PLL: srcOneHot = 3'b100;
      default:  srcOneHot = 3'b010;
    endcase
  endfunction

  function automatic logic [DIV_W-1:0] divLastOf(input logic [1:0] code);
    case (code)
      2'b00:   divLastOf = DIV_W'(0);
      2'b01:   divLastOf = DIV_W'(3);
      2'b10:   divLastOf = DIV_W'(7);
      default: divLastOf = DIV_W'(15);
    endcase
  endfunction
endpackage

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl
  import sysclk_pkg::*;
#(
  parameter bit TWO_CLK = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wrSel,
  input  logic [1:0]  selQ,
  input  logic        subStopQ,
  input  logic        subReady,
  input  logic        pllLock,
  output logic [1:0]  curMode,
  output logic [2:0]  srcEn,
  output ctrlStrobe_t strobe
);
  logic pending;
  logic selValid;
  logic goNow;

  always_comb begin
    pending  = (selQ != curMode);
    selValid = (wrSel == MODE_MAIN) || (wrSel == MODE_PLL) ||
               (TWO_CLK && (wrSel == MODE_SUB));
    case (selQ)
      MODE_MAIN: goNow = pending;
      MODE_PLL:  goNow = pending && pllLock;
      MODE_SUB:  goNow = pending && subReady && TWO_CLK;
      default:   goNow = 1'b0;
    endcase
  end

  always_comb begin
    strobe.selLoad  = wrEn && !pending && selValid;
    strobe.modeGo   = goNow;
    strobe.subOscEn = TWO_CLK && ((curMode == MODE_SUB) || (selQ == MODE_SUB) || !subStopQ);
    strobe.pllEn    = (curMode == MODE_PLL) || (selQ == MODE_PLL);
  end

  always_ff @(posedge clk) begin
    if (!rstN)      curMode <= MODE_MAIN;
    else if (goNow) curMode <= selQ;
  end

  always_comb srcEn = srcOneHot(curMode);

  p_mode_legal_r2: assert property (@(posedge clk) disable iff (!rstN)
    curMode != MODE_BAD);

  p_pll_entry_r6: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_PLL && $past(curMode) != MODE_PLL) |-> $past(pllLock));

  p_sub_entry_r7: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_SUB && $past(curMode) != MODE_SUB) |-> $past(subReady));

  p_no_sub_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    !TWO_CLK |-> (curMode != MODE_SUB && selQ != MODE_SUB));
endmodule

// File: rtl/sysclk_dpath.sv
module sysclk_dpath
  import sysclk_pkg::*;
#(
  parameter bit TWO_CLK  = 1'b1,
  parameter int SUB_WAIT = 256
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [7:0]  wrData,
  input  ctrlStrobe_t strobe,
  input  logic [1:0]  curMode,
  output logic [1:0]  selQ,
  output logic        subStopQ,
  output logic        subReady,
  output logic [1:0]  divQ,
  output logic        mclkTick,
  output logic [7:0]  rdData
);
  localparam int SUB_CW = $clog2(SUB_WAIT + 1);
  localparam logic [SUB_CW-1:0] SUB_DONE = SUB_CW'(SUB_WAIT);

  logic unusedMonWr;
  assign unusedMonWr = ^wrData[7:6];

  always_ff @(posedge clk) begin
    if (!rstN)               selQ <= MODE_MAIN;
    else if (strobe.selLoad) selQ <= wrData[5:4];
  end

  always_ff @(posedge clk) begin
    if (!rstN)     divQ <= 2'b00;
    else if (wrEn) divQ <= wrData[1:0];
  end

  generate
    if (TWO_CLK) begin : g_sub
      logic [SUB_CW-1:0] subCnt;

      always_ff @(posedge clk) begin
        if (!rstN)     subStopQ <= 1'b0;
        else if (wrEn) subStopQ <= wrData[2];
      end

      always_ff @(posedge clk) begin
        if (!rstN || !strobe.subOscEn) subCnt <= '0;
        else if (subCnt != SUB_DONE)   subCnt <= subCnt + 1'b1;
      end

      assign subReady = (subCnt == SUB_DONE);

      p_sub_stop_r8: assert property (@(posedge clk) disable iff (!rstN)
        !strobe.subOscEn |=> !subReady);
    end else begin : g_nosub
      logic unusedSubWr;
      assign unusedSubWr = ^wrData[3:2];
      assign subStopQ    = 1'b0;
      assign subReady    = 1'b0;
    end
  endgenerate

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLast;
  logic             divRestart;

  always_comb begin
    divLast    = divLastOf(divQ);
    divRestart = strobe.modeGo || (wrEn && (wrData[1:0] != divQ));
  end

  always_ff @(posedge clk) begin
    if (!rstN || divRestart)   divCnt <= '0;
    else if (divCnt >= divLast) divCnt <= '0;
    else                        divCnt <= divCnt + 1'b1;
  end

  assign mclkTick = (divCnt == '0);
  assign rdData   = {curMode, selQ, subReady, subStopQ, divQ};

  p_sel_lock_r3: assert property (@(posedge clk) disable iff (!rstN)
    (selQ != curMode) |=> (selQ == $past(selQ)));

  p_div_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    divCnt <= divLast);

  p_restart_r10: assert property (@(posedge clk) disable iff (!rstN)
    divRestart |=> mclkTick);
endmodule

// File: rtl/sysclk_mode_ctrl.sv
module sysclk_mode_ctrl
  import sysclk_pkg::*;
#(
  parameter bit TWO_CLK  = 1'b1,
  parameter int SUB_WAIT = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       pllLock,
  output logic [7:0] rdData,
  output logic [1:0] modeOut,
  output logic [2:0] srcEn,
  output logic       subOscEn,
  output logic       pllEn,
  output logic [1:0] divSel,
  output logic       mclkTick
);
  ctrlStrobe_t strobe;
  logic [1:0]  curMode;
  logic [1:0]  selQ;
  logic        subStopQ;
  logic        subReady;

  sysclk_ctrl #(.TWO_CLK(TWO_CLK)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrData[5:4]),
    .selQ(selQ), .subStopQ(subStopQ), .subReady(subReady), .pllLock(pllLock),
    .curMode(curMode), .srcEn(srcEn), .strobe(strobe)
  );

  sysclk_dpath #(.TWO_CLK(TWO_CLK), .SUB_WAIT(SUB_WAIT)) u_dpath (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .strobe(strobe),
    .curMode(curMode), .selQ(selQ), .subStopQ(subStopQ), .subReady(subReady),
    .divQ(divSel), .mclkTick(mclkTick), .rdData(rdData)
  );

  assign modeOut  = curMode;
  assign subOscEn = strobe.subOscEn;
  assign pllEn    = strobe.pllEn;
endmodule

// File: tb/tb_sysclk_mode_ctrl.sv
module tb_sysclk_mode_ctrl;
  localparam int SW = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, wrEn1 = 1'b0;
  logic [7:0] wrData = '0, wrData1 = '0;
  logic pllLock = 1'b0;
  logic [7:0] rdData, rdData1;
  logic [1:0] modeOut, modeOut1, divSel, divSel1;
  logic [2:0] srcEn, srcEn1;
  logic subOscEn, subOscEn1, pllEn, pllEn1, mclkTick, mclkTick1;
  int nChecks = 0, nFails = 0;

  always #5 clk = ~clk;

  sysclk_mode_ctrl #(.TWO_CLK(1'b1), .SUB_WAIT(SW)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .pllLock(pllLock),
    .rdData(rdData), .modeOut(modeOut), .srcEn(srcEn), .subOscEn(subOscEn),
    .pllEn(pllEn), .divSel(divSel), .mclkTick(mclkTick));

  sysclk_mode_ctrl #(.TWO_CLK(1'b0), .SUB_WAIT(SW)) dutSingle (
    .clk(clk), .rstN(rstN), .wrEn(wrEn1), .wrData(wrData1), .pllLock(pllLock),
    .rdData(rdData1), .modeOut(modeOut1), .srcEn(srcEn1), .subOscEn(subOscEn1),
    .pllEn(pllEn1), .divSel(divSel1), .mclkTick(mclkTick1));

  function automatic logic [7:0] expRd(logic [1:0] m, logic [1:0] s, logic r, logic st, logic [1:0] d);
    return {m, s, r, st, d};
  endfunction

  function automatic int expPeriod(logic [1:0] d);
    case (d)
      2'b00: return 1;
      2'b01: return 4;
      2'b10: return 8;
      default: return 16;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr2(logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic wr1(logic [7:0] d);
    @(negedge clk); wrEn1 = 1'b1; wrData1 = d;
    @(negedge clk); wrEn1 = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [1:0] d;
    int ticks;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 read byte", rdData, 8'hA0);
    chk("R1 source enable", srcEn, 3'b010);
    chk("R1 single read byte", rdData1, 8'hA0);

    repeat (SW + 2) @(negedge clk);
    chk("R8 ready after wait", rdData[3], 1'b1);

    wr2(8'h60);
    chk("R2 monitor unwritable", rdData, expRd(2'b10, 2'b10, 1'b1, 1'b0, 2'b00));
    wr2(8'h90);
    chk("R4 code 01 ignored", rdData[5:4], 2'b10);
    @(negedge clk);
    chk("R2 mode stays main", modeOut, 2'b10);

    // R10 directed restart on a divide change
    wr2(8'hA1);
    chk("R10 tick on restart", mclkTick, 1'b1);
    for (int i = 1; i < 4; i++) begin
      @(negedge clk);
      chk("R10 no tick inside period", mclkTick, 1'b0);
    end
    @(negedge clk);
    chk("R10 tick after 4", mclkTick, 1'b1);

    // R9 random divide ratios
    for (int it = 0; it < 24; it++) begin
      d = 2'($urandom);
      wr2({4'b1010, 2'b00, d});
      chk("R9 divide field", rdData[1:0], d);
      ticks = 0;
      for (int c = 0; c < 32; c++) begin
        if (mclkTick) ticks++;
        @(negedge clk);
      end
      chk("R9 tick count", ticks, 32 / expPeriod(d));
    end

    // R6 / R3 PLL request held by lockout
    wr2(8'hB3);
    chk("R6 request read", rdData, 8'hBB);
    chk("R6 pll enabled", pllEn, 1'b1);
    wr2(8'hA3);
    chk("R3 select locked", rdData[5:4], 2'b11);
    repeat (3) @(negedge clk);
    chk("R6 waits for lock", modeOut, 2'b10);
    pllLock = 1'b1;
    @(negedge clk);
    chk("R6 mode pll", modeOut, 2'b11);
    chk("R6 source pll", srcEn, 3'b100);
    chk("R10 tick on mode change", mclkTick, 1'b1);
    @(negedge clk);
    chk("R10 no tick after restart", mclkTick, 1'b0);

    // R5 back to main
    wr2(8'hA3);
    chk("R5 not yet switched", modeOut, 2'b11);
    @(negedge clk);
    chk("R5 mode main", modeOut, 2'b10);
    chk("R5 source main", srcEn, 3'b010);
    pllLock = 1'b0;
    chk("R6 pll released", pllEn, 1'b0);

    // R8 stop subclock in main mode
    wr2(8'hA7);
    chk("R8 osc stopped", subOscEn, 1'b0);
    @(negedge clk);
    chk("R8 ready cleared", rdData, 8'hA7);

    // R7 subclock request from stopped state
    wr2(8'h87);
    chk("R7 request read", rdData, 8'h87);
    chk("R7 osc re-enabled", subOscEn, 1'b1);
    repeat (SW - 1) @(negedge clk);
    chk("R7 not ready early", rdData[3], 1'b0);
    chk("R7 mode held", modeOut, 2'b10);
    @(negedge clk);
    chk("R7 ready", rdData[3], 1'b1);
    chk("R7 mode still main", modeOut, 2'b10);
    @(negedge clk);
    chk("R7 mode sub", modeOut, 2'b00);
    chk("R7 source sub", srcEn, 3'b001);

    repeat (5) @(negedge clk);
    chk("R8 stop ignored in sub", subOscEn, 1'b1);
    chk("R8 ready kept in sub", rdData[3], 1'b1);

    wr2(8'hA7);
    @(negedge clk);
    chk("R5 sub to main", modeOut, 2'b10);
    chk("R8 osc stops after leaving sub", subOscEn, 1'b0);
    @(negedge clk);
    chk("R8 ready drops", rdData[3], 1'b0);

    // R11 / R4 single-oscillator variant
    wr1(8'h00);
    chk("R4 single sub request dropped", rdData1, 8'hA0);
    wr1(8'h9D);
    chk("R11 single bits read zero", rdData1, 8'hA1);
    chk("R11 single osc off", subOscEn1, 1'b0);
    wr1(8'h33);
    chk("R11 single pll request", rdData1, 8'hB3);
    pllLock = 1'b1;
    @(negedge clk);
    chk("R11 single pll mode", modeOut1, 2'b11);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule